// File: doc/BRIEF.md
# Greedy Table Subtraction Converter

This block turns a 32-bit operand into a 32-bit selection code. It walks through a table of 32 unsigned weights held in an external memory. The walk starts at a base address and goes one word per step. At each step the current weight is compared with a working value. If the weight is no larger than the working value, it is subtracted and the matching code bit is set. Otherwise both stay as they are. After the last step the block reports two results: the remainder left in the working value, and the code showing which weights were taken. It also reports a two-bit sign/zero condition on the code.

The block issues one memory read per step and waits for the data-valid strobe before it decides. Any memory latency is therefore tolerated. An abort during a conversion drops the sequence and leaves all result outputs untouched, so the caller can start again from the beginning. A typical use is decimal-to-binary conversion, or any other weighted decomposition driven by a table.

Top module: `greedy_conv`

## Requirements
- R1: After reset `busy`, `done`, `rd_req`, `remainder`, `code` and `cc` are all zero.
- R2: A `start` pulse while idle latches `operand` and `base_addr` and sets `busy`. For step n (0..31) exactly one single-cycle `rd_req` is issued with `rd_addr` = base + n. The next request is only issued after `rd_valid` has answered the current one.
- R3: Weights and the working value are compared and subtracted as unsigned 32-bit numbers. `remainder` equals the operand minus the sum of all weights taken.
- R4: The code uses most-significant-first numbering: taking the weight of step n sets `code[31-n]`. Bits of steps that were not taken are 0.
- R5: A weight exactly equal to the working value is taken, which leaves a working value of 0.
- R6: After the 32nd `rd_valid`, `done` is high for exactly one cycle. `remainder`, `code` and `cc` change on the same edge that raises `done`, and at no other time. `busy` falls on that same edge.
- R7: `cc` is 2'b00 when the code is zero, 2'b01 when `code[31]` is 1, and 2'b10 when `code[31]` is 0 and some other bit is 1.
- R8: `abort` while busy returns the block to idle on the next edge. No `done` is produced, and `remainder`, `code` and `cc` keep their previous values. A later `start` converts normally. `abort` while idle has no effect.
- R9: `start` while busy is ignored: the running conversion finishes with its original operand and base.
- R10: `rd_valid` arriving any number of cycles after `rd_req` is accepted. While no request is outstanding, `rd_valid` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a conversion when idle |
| abort | input | 1 | Drop the running conversion |
| operand | input | 32 | Value to decompose |
| base_addr | input | 16 | Address of table entry 0 |
| rd_req | output | 1 | Single-cycle read request |
| rd_addr | output | 16 | Read address, base plus step index |
| rd_valid | input | 1 | Read data is valid |
| rd_data | input | 32 | Weight returned by memory |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle completion strobe |
| remainder | output | 32 | Working value left after the last step |
| code | output | 32 | Mask of weights taken, step 0 in bit 31 |
| cc | output | 2 | Zero/sign condition on the code |

## Verification
The bench tries several tables:
- A table of descending powers of two must reproduce the operand as the code with a zero remainder. This separates correct bit numbering from a reversed one.
- A table with weights above 2^31 tells an unsigned compare apart from a signed one.
- An all-zero table takes every step.
- An all-ones table takes at most one step.
- A pseudo-random table gives a mixed mask.
- An operand equal to the first weight shows whether the less-or-equal boundary is honoured.

Each table is run with zero, varied and long memory latency. Stray valid strobes arrive while no request is outstanding. Aborts are applied mid-sequence and start pulses are sent while the block is busy. These cases show whether outputs stay frozen outside the completion edge.

// File: rtl/greedy_conv.sv
module greedy_conv #(
  parameter int W  = 32,
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          abort,
  input  logic [W-1:0]  operand,
  input  logic [AW-1:0] base_addr,
  output logic          rd_req,
  output logic [AW-1:0] rd_addr,
  input  logic          rd_valid,
  input  logic [W-1:0]  rd_data,
  output logic          busy,
  output logic          done,
  output logic [W-1:0]  remainder,
  output logic [W-1:0]  code,
  output logic [1:0]    cc
);
  localparam int NW = $clog2(W);
  localparam logic [NW-1:0] LAST = NW'(W - 1);

  typedef enum logic [1:0] {IDLE, REQ, WAIT} state_t;
  state_t state;

  logic [W-1:0]  acc, mask;
  logic [NW-1:0] idx;
  logic [AW-1:0] base_q;

  wire          take    = rd_data <= acc;
  wire [W-1:0]  sel_bit = W'(1) << (LAST - idx);
  wire [W-1:0]  acc_nx  = take ? acc + (~rd_data + W'(1)) : acc;
  wire [W-1:0]  mask_nx = take ? (mask | sel_bit) : mask;
  wire          step    = (state == WAIT) && rd_valid;
  wire          finish  = step && (idx == LAST);

  assign rd_req  = (state == REQ);
  assign rd_addr = base_q + AW'(idx);
  assign busy    = (state != IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= IDLE;
      acc       <= '0;
      mask      <= '0;
      idx       <= '0;
      base_q    <= '0;
      done      <= 1'b0;
      remainder <= '0;
      code      <= '0;
      cc        <= 2'b00;
    end else begin
      done <= 1'b0;
      case (state)
        IDLE: if (start) begin
          acc    <= operand;
          mask   <= '0;
          idx    <= '0;
          base_q <= base_addr;
          state  <= REQ;
        end
        REQ: state <= abort ? IDLE : WAIT;
        WAIT: if (abort) begin
          state <= IDLE;
        end else if (step) begin
          acc  <= acc_nx;
          mask <= mask_nx;
          if (finish) begin
            state     <= IDLE;
            done      <= 1'b1;
            remainder <= acc_nx;
            code      <= mask_nx;
            cc        <= (mask_nx == '0) ? 2'b00 : (mask_nx[W-1] ? 2'b01 : 2'b10);
          end else begin
            idx   <= idx + NW'(1);
            state <= REQ;
          end
        end
        default: state <= IDLE;
      endcase
    end
  end
endmodule

// File: rtl/greedy_conv_chk.sv
module greedy_conv_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         abort,
  input logic         busy,
  input logic         done,
  input logic         rd_req,
  input logic [W-1:0] remainder,
  input logic [W-1:0] code,
  input logic [1:0]   cc
);
  // R6
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R6
  code_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n) !$stable(code) |-> done);
  // R6
  rem_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n) !$stable(remainder) |-> done);
  // R2
  req_single_chk: assert property (@(posedge clk) disable iff (!rst_n) rd_req |=> !rd_req);
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> !rd_req);
  // R7
  cc_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cc == ((code == '0) ? 2'b00 : (code[W-1] ? 2'b01 : 2'b10))));
  // R8
  abort_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && abort) |=> (!busy && !done && $stable(code) && $stable(cc)));
  // R9
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !abort && !rd_req) |=> (busy || done));
endmodule

bind greedy_conv greedy_conv_chk #(.W(W)) chk_i (.*);

// File: tb/greedy_conv_tb.sv
`timescale 1ns/1ps
module greedy_conv_tb_top;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n = 1'b0, start = 1'b0, abort = 1'b0, rd_valid = 1'b0;
  logic [31:0] operand = '0, rd_data = '0;
  logic [15:0] base_addr = '0;
  logic        rd_req, busy, done;
  logic [15:0] rd_addr;
  logic [31:0] remainder, code;
  logic [1:0]  cc;

  greedy_conv dut_i (.*);

  int checks = 0, errors = 0, cycles = 0;
  logic [31:0] mem [0:255];

  // memory responder
  int lat_mode = 0, req_no = 0, pend_cnt = 0;
  bit pending = 0, stray = 0;
  logic [31:0] pend_data;
  always @(negedge clk) begin
    #1;
    rd_valid = 1'b0;
    if (pending && abort) pending = 0;
    if (pending) begin
      if (pend_cnt == 0) begin rd_valid = 1'b1; rd_data = pend_data; pending = 0; end
      else pend_cnt--;
    end else if (stray && !rd_req) begin
      rd_valid = 1'b1; rd_data = 32'h0;   // R10 stray strobe with no request
    end
    if (rd_req && !abort) begin
      pending = 1; pend_data = mem[rd_addr[7:0]]; req_no++;
      pend_cnt = (lat_mode == 0) ? 0 : (lat_mode == 1) ? (req_no * 5) % 4 : 6;
    end
  end

  // behavioural reference
  bit m_busy = 0, m_wait = 0, e_done = 0;
  int m_cnt = 0;
  logic [15:0] m_base;
  logic [31:0] p_rem, p_code, e_rem = 0, e_code = 0;
  logic [1:0]  e_cc = 0;

  function automatic logic [1:0] ccf(logic [31:0] b);
    return (b == 0) ? 2'd0 : (b[31] ? 2'd1 : 2'd2);
  endfunction

  task automatic predict(logic [15:0] b, logic [31:0] op);
    longint unsigned a = op;
    p_code = 0;
    for (int i = 0; i < 32; i++) begin
      longint unsigned w = mem[8'(b + 16'(i))];
      if (w <= a) begin a -= w; p_code[31 - i] = 1'b1; end
    end
    p_rem = 32'(a);
  endtask

  always @(posedge clk) begin
    e_done = 0;
    if (!rst_n) begin m_busy = 0; m_wait = 0; end
    else if (m_busy) begin
      if (abort) m_busy = 0;
      else if (m_wait && rd_valid) begin
        m_cnt++; m_wait = 0;
        if (m_cnt == 32) begin
          m_busy = 0; e_done = 1; e_rem = p_rem; e_code = p_code; e_cc = ccf(p_code);
        end
      end else if (rd_req) m_wait = 1;
    end else if (start) begin
      m_busy = 1; m_wait = 0; m_cnt = 0; m_base = base_addr; predict(base_addr, operand);
    end
  end

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h at cycle %0d", req, what, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      chk(busy == m_busy, "R2/R8/R9", "busy", 32'(busy), 32'(m_busy));
      chk(done == e_done, "R6", "done", 32'(done), 32'(e_done));
      chk(remainder == e_rem, "R3/R5", "remainder", remainder, e_rem);
      chk(code == e_code, "R4", "code", code, e_code);
      chk(cc == e_cc, "R7", "cc", 32'(cc), 32'(e_cc));
      if (rd_req) chk(rd_addr == m_base + 16'(m_cnt), "R2", "rd_addr", 32'(rd_addr), 32'(m_base + 16'(m_cnt)));
    end
  end

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  task automatic kick(logic [15:0] b, logic [31:0] op);
    @(negedge clk); start = 1; base_addr = b; operand = op;
    @(negedge clk); start = 0;
  endtask

  task automatic convert(logic [15:0] b, logic [31:0] op);
    kick(b, op);
    while (!done) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 32; i++) begin
      mem[i]       = 32'h8000_0000 >> i;
      mem[32 + i]  = 32'hE000_0000 >> (i / 2);
      mem[64 + i]  = 32'h0;
      mem[96 + i]  = 32'hFFFF_FFFF;
      mem[128 + i] = (32'(i) * 32'h9E37_79B9) ^ 32'h5A5A_0000;
    end
    for (int i = 160; i < 256; i++) mem[i] = 32'(i * 1000);
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!busy && !done && !rd_req, "R1", "ctrl", {29'b0, busy, done, rd_req}, 0);
    chk(remainder == 0 && code == 0 && cc == 0, "R1", "outputs", code, 0);
    rst_n = 1;
    for (int m = 0; m < 3; m++) begin
      lat_mode = m;
      convert(0, 32'hA5C3_0F96);   // R4 identity, cc 01
      convert(0, 32'h1234_5678);   // R7 cc 10
      convert(0, 32'h8000_0000);   // R5 equality on step 0
      convert(32, 32'hF000_0001);  // R3 unsigned weights above 2^31
      convert(64, 32'h0000_BEEF);  // all taken
      convert(96, 32'hFFFF_FFFF);  // R5 one taken
      convert(96, 32'h0);          // R7 cc 00
      convert(128, 32'hDEAD_BEEF);
      convert(160, 32'h0001_0000);
    end
    // R10 stray strobes while idle and between requests
    lat_mode = 2; stray = 1;
    convert(128, 32'h7777_1234);
    stray = 0;
    // R8 abort mid-sequence, outputs frozen, then restart
    lat_mode = 1;
    kick(0, 32'h0F0F_0F0F);
    repeat (40) @(negedge clk);
    abort = 1; @(negedge clk); abort = 0;
    repeat (10) @(negedge clk);
    abort = 1; @(negedge clk); abort = 0;   // R8 abort while idle
    convert(0, 32'h0F0F_0F0F);
    // R9 start while busy ignored
    kick(32, 32'hC000_0000);
    repeat (20) @(negedge clk);
    start = 1; operand = 32'h1; base_addr = 64; @(negedge clk); start = 0;
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule